// File: doc/BRIEF.md
# Greyscale Dither Pixel Serializer

This block drives a one-bit-per-pixel monochrome display so that a sequence of refreshed frames shows grey levels. Each pixel owns an 8-bit grey value and an 8-bit phase accumulator. Both are held in two small on-chip memories. On every request the block walks a run of pixels in groups of eight. For each pixel it sends the sign of the phase as the display bit, then stores back the phase with its top bit forced high and the grey value subtracted. Over many frames, a pixel with a larger value spends a larger share of frames dark. The result is temporal dithering rather than a stored bitmap.

A host first fills the memories through a simple write port while the block is idle. It then issues one request per frame, giving the number of eight-pixel groups to send. Each group leaves as one byte on a valid/ready output. The byte is display data. When no byte is offered, the output lines rest at all-ones. A one-cycle done pulse closes the request.

Top module: `gs_dither_serializer`

## Requirements
- R1: After reset, busy_o, out_valid_o and done_o are low and out_data_o is 8'hFF.
- R2: While the block is idle, a load with ld_sel_i = 0 writes the phase of pixel ld_addr_i and a load with ld_sel_i = 1 writes its grey value. Loads issued while busy_o is high change neither memory.
- R3: A start_i with nblk_i = n (1 to the group count) produces exactly n output bytes. Group g covers pixels 8g to 8g+7, and groups go out in ascending order. A start_i seen while busy is ignored.
- R4: The output bit of a pixel equals bit 7 of its phase before the update. Within a byte, the pixel at offset 0 of the group sits in bit 7 and the pixel at offset 7 sits in bit 0.
- R5: After a pixel is sent, its phase becomes ((phase | 8'h80) - value) mod 256, with no borrow into any other pixel. The next request sends this new phase.
- R6: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o holds its value. No further group is processed until the byte is accepted.
- R7: done_o is high for exactly one cycle, in the cycle after the last byte is accepted. busy_o is low from the following cycle.
- R8: A start_i with nblk_i = 0 offers no byte and gives the done pulse in the next cycle.
- R9: A pixel with grey value 0 and phase at or above 8'h80 sends 1 on every request.
- R10: Whenever out_valid_o is low, out_data_o rests at 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_en_i | input | 1 | Memory load strobe (honoured only when idle) |
| ld_sel_i | input | 1 | Load target: 0 phase, 1 grey value |
| ld_addr_i | input | PIX_AW | Pixel index to load |
| ld_data_i | input | 8 | Byte to load |
| start_i | input | 1 | Request strobe |
| nblk_i | input | PIX_AW-2 | Number of eight-pixel groups in the request |
| busy_o | output | 1 | Request in progress |
| out_valid_o | output | 1 | Output byte offered |
| out_data_o | output | 8 | Output byte, 8'hFF when not offered |
| out_ready_i | input | 1 | Sink accepts the offered byte |
| done_o | output | 1 | One-cycle end-of-request pulse |

## Verification
The bench builds the block with PIX_AW = 5, which gives 32 pixels in four groups. A full-length request therefore reaches the top address and the last value of the group counter at small cost. The same width keeps the zero-group request and the clamp-free maximum count cheap to reach. The bench runs several frames over a table of phase and value pairs, so that wraparound of the accumulator and saturation at value 0 appear within a few requests.

// File: rtl/gs_pkg.sv
`timescale 1ns/1ps
package gs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_SEND, ST_DONE} gs_state_e;
  localparam logic [7:0] SIGN_MASK = 8'h80;
  localparam logic [7:0] IDLE_LINE = 8'hFF;
endpackage

// File: rtl/gs_ram.sv
`timescale 1ns/1ps
module gs_ram #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic          re_i,
  input  logic [AW-1:0] ra_i,
  output logic [DW-1:0] rd_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wa_i] <= wd_i;
    if (re_i) rd_o <= mem_q[ra_i];
  end
endmodule

// File: rtl/gs_pix_step.sv
`timescale 1ns/1ps
module gs_pix_step
  import gs_pkg::*;
(
  input  logic [7:0] phase_i,
  input  logic [7:0] value_i,
  output logic       bit_o,
  output logic [7:0] phase_o
);
  // per-pixel 8-bit lane, no carry path to neighbours
  assign bit_o   = phase_i[7];
  assign phase_o = (phase_i | SIGN_MASK) - value_i;
endmodule

// File: rtl/gs_dither_serializer.sv
`timescale 1ns/1ps
module gs_dither_serializer
  import gs_pkg::*;
#(
  parameter int PIX_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_en_i,
  input  logic              ld_sel_i,
  input  logic [PIX_AW-1:0] ld_addr_i,
  input  logic [7:0]        ld_data_i,
  input  logic              start_i,
  input  logic [PIX_AW-3:0] nblk_i,
  output logic              busy_o,
  output logic              out_valid_o,
  output logic [7:0]        out_data_o,
  input  logic              out_ready_i,
  output logic              done_o
);
  localparam int BLK_AW = PIX_AW - 3;
  localparam int CNT_W  = BLK_AW + 1;

  gs_state_e         state_q;
  logic [BLK_AW-1:0] blk_q;
  logic [CNT_W-1:0]  nblk_q;
  logic [CNT_W-1:0]  bytes_q;
  logic [3:0]        cnt_q;
  logic              p_vld_q;
  logic [PIX_AW-1:0] p_addr_q;
  logic [7:0]        sreg_q;

  logic              rd_en;
  logic [PIX_AW-1:0] rd_addr;
  logic [7:0]        ph_rd, val_rd, ph_nxt;
  logic              pix_bit;
  logic              ph_we, val_we, idle_ld;
  logic [PIX_AW-1:0] ph_wa;
  logic [7:0]        ph_wd;
  logic              hs, last_blk;

  assign rd_en   = (state_q == ST_RUN) && !cnt_q[3];
  assign rd_addr = {blk_q, cnt_q[2:0]};
  assign idle_ld = (state_q == ST_IDLE) && ld_en_i;
  assign ph_we   = p_vld_q || (idle_ld && !ld_sel_i);
  assign ph_wa   = p_vld_q ? p_addr_q : ld_addr_i;
  assign ph_wd   = p_vld_q ? ph_nxt : ld_data_i;
  assign val_we  = idle_ld && ld_sel_i;

  gs_ram #(.AW(PIX_AW), .DW(8)) u_phase_ram (
    .clk_i(clk_i), .we_i(ph_we), .wa_i(ph_wa), .wd_i(ph_wd),
    .re_i(rd_en), .ra_i(rd_addr), .rd_o(ph_rd)
  );

  gs_ram #(.AW(PIX_AW), .DW(8)) u_value_ram (
    .clk_i(clk_i), .we_i(val_we), .wa_i(ld_addr_i), .wd_i(ld_data_i),
    .re_i(rd_en), .ra_i(rd_addr), .rd_o(val_rd)
  );

  gs_pix_step u_step (
    .phase_i(ph_rd), .value_i(val_rd), .bit_o(pix_bit), .phase_o(ph_nxt)
  );

  assign out_valid_o = (state_q == ST_SEND);
  assign out_data_o  = out_valid_o ? sreg_q : IDLE_LINE;
  assign done_o      = (state_q == ST_DONE);
  assign busy_o      = (state_q != ST_IDLE);
  assign hs          = out_valid_o && out_ready_i;
  assign last_blk    = (CNT_W'(blk_q) + CNT_W'(1)) == nblk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      blk_q    <= '0;
      nblk_q   <= '0;
      bytes_q  <= '0;
      cnt_q    <= '0;
      p_vld_q  <= 1'b0;
      p_addr_q <= '0;
      sreg_q   <= '0;
    end else begin
      p_vld_q  <= rd_en;
      p_addr_q <= rd_addr;
      if (p_vld_q) sreg_q <= {sreg_q[6:0], pix_bit};
      if (hs) bytes_q <= bytes_q + CNT_W'(1);
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          nblk_q  <= nblk_i;
          bytes_q <= '0;
          blk_q   <= '0;
          cnt_q   <= '0;
          state_q <= (nblk_i == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 4'd1;
          if (cnt_q == 4'd8) state_q <= ST_SEND;
        end
        ST_SEND: if (out_ready_i) begin
          if (last_blk) state_q <= ST_DONE;
          else begin
            blk_q   <= blk_q + BLK_AW'(1);
            cnt_q   <= '0;
            state_q <= ST_RUN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r6_hold_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  a_r3_byte_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> bytes_q == nblk_q);

  a_r9_zero_value_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_vld_q && (val_rd == 8'h00) && ph_rd[7] |-> ph_nxt[7]);

  a_r6_no_run_while_offered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !rd_en && !p_vld_q);
endmodule

// File: tb/gs_dither_serializer_tb_top.sv
`timescale 1ns/1ps
module gs_dither_serializer_tb_top;
  localparam int PIX_AW = 5;
  localparam int NPIX   = 1 << PIX_AW;
  localparam int NBLK   = NPIX / 8;
  // {phase, value} for pixels 0..15
  localparam logic [15:0] VEC [16] = '{
    16'h0000, 16'h8000, 16'h4040, 16'hFF01, 16'h7FFF, 16'h8080, 16'h1033, 16'hC055,
    16'h00FF, 16'hAA20, 16'h5599, 16'h8001, 16'h017F, 16'hFEC8, 16'h3366, 16'h9010
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ld_en_i = 1'b0, ld_sel_i = 1'b0;
  logic [PIX_AW-1:0] ld_addr_i = '0;
  logic [7:0] ld_data_i = '0;
  logic start_i = 1'b0;
  logic [PIX_AW-3:0] nblk_i = '0;
  logic busy_o, out_valid_o, done_o;
  logic [7:0] out_data_o;
  logic out_ready_i = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m_ph [NPIX];
  logic [7:0] m_val [NPIX];
  logic [7:0] exp_b [NBLK];
  logic [7:0] got_b [NBLK];

  always #2.5 clk = ~clk;

  gs_dither_serializer #(.PIX_AW(PIX_AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ld_en_i(ld_en_i), .ld_sel_i(ld_sel_i),
    .ld_addr_i(ld_addr_i), .ld_data_i(ld_data_i), .start_i(start_i), .nblk_i(nblk_i),
    .busy_o(busy_o), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
    .out_ready_i(out_ready_i), .done_o(done_o)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ld(input logic sel, input int addr, input logic [7:0] d);
    @(negedge clk);
    ld_en_i = 1'b1; ld_sel_i = sel; ld_addr_i = PIX_AW'(addr); ld_data_i = d;
    @(negedge clk);
    ld_en_i = 1'b0;
    if (sel) m_val[addr] = d; else m_ph[addr] = d;
  endtask

  task automatic model_frame(input int nb);
    for (int b = 0; b < nb; b++) begin
      for (int k = 0; k < 8; k++) begin
        exp_b[b][7-k] = m_ph[8*b+k][7];
        m_ph[8*b+k] = (m_ph[8*b+k] | 8'h80) - m_val[8*b+k];
      end
    end
  endtask

  // poke: 0 none, 1 second start while busy, 2 load while busy
  task automatic run_frame(input int nb, input bit stall, input int poke);
    model_frame(nb);
    @(negedge clk);
    start_i = 1'b1; nblk_i = (PIX_AW-2)'(nb);
    @(negedge clk);
    start_i = 1'b0;
    if (poke == 1) begin
      start_i = 1'b1; nblk_i = (PIX_AW-2)'(NBLK);
      @(negedge clk);
      start_i = 1'b0;
    end else if (poke == 2) begin
      ld_en_i = 1'b1; ld_sel_i = 1'b1; ld_addr_i = '0; ld_data_i = 8'h5A;
      @(negedge clk);
      ld_en_i = 1'b1; ld_sel_i = 1'b0; ld_addr_i = '0; ld_data_i = 8'h00;
      @(negedge clk);
      ld_en_i = 1'b0;
    end
    for (int b = 0; b < nb; b++) begin
      for (int t = 0; t < 40 && !out_valid_o; t++) @(negedge clk);
      chk(out_valid_o, "R3 byte offered", 32'(out_valid_o), 1);
      if (stall) begin
        for (int s = 0; s < 3; s++) begin
          @(negedge clk);
          chk(out_valid_o && out_data_o == exp_b[b], "R6 held under backpressure", out_data_o, exp_b[b]);
        end
      end
      got_b[b] = out_data_o;
      chk(out_data_o == exp_b[b], "R4 R5 byte content", out_data_o, exp_b[b]);
      out_ready_i = 1'b1;
      @(negedge clk);
      out_ready_i = 1'b0;
    end
    chk(done_o == 1'b1 && !out_valid_o, "R7 done after last accept", 32'(done_o), 1);
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R7 done single cycle", {done_o, busy_o}, 0);
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      chk(!out_valid_o && out_data_o == 8'hFF, "R3 R10 no extra byte, idle line", out_data_o, 8'hFF);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired in all requirements actual=hang expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 R10: reset state
    chk(!busy_o && !out_valid_o && !done_o, "R1 reset outputs", {busy_o, out_valid_o, done_o}, 0);
    chk(out_data_o == 8'hFF, "R10 idle line after reset", out_data_o, 8'hFF);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o && out_data_o == 8'hFF, "R1 idle after release", out_data_o, 8'hFF);

    // R2: table walk loads pixels 0..15, others computed
    for (int i = 0; i < 16; i++) begin
      ld(1'b0, i, VEC[i][15:8]);
      ld(1'b1, i, VEC[i][7:0]);
    end
    for (int i = 16; i < NPIX; i++) begin
      ld(1'b0, i, 8'(i * 7));
      ld(1'b1, i, 8'(i * 13 + 5));
    end

    // R4 R5 R9: several frames over the table
    for (int f = 0; f < 5; f++) begin
      run_frame(2, 1'b0, 0);
      chk(got_b[0][6] == 1'b1, "R9 zero value pixel stays 1", 32'(got_b[0][6]), 1);
    end

    // R6: backpressure
    run_frame(2, 1'b1, 0);

    // R3: full length, ascending groups
    run_frame(NBLK, 1'b0, 0);
    run_frame(NBLK, 1'b1, 0);

    // R3: start while busy ignored
    run_frame(1, 1'b0, 1);

    // R2: loads while busy ignored (model keeps old pixel 0)
    run_frame(2, 1'b0, 2);
    run_frame(2, 1'b0, 0);

    // R4: directed bit order, only pixel 0 of group 0 set
    for (int k = 0; k < 8; k++) begin
      ld(1'b0, k, (k == 0) ? 8'h80 : 8'h00);
      ld(1'b1, k, 8'h00);
    end
    run_frame(1, 1'b0, 0);
    chk(got_b[0] == 8'h80, "R4 offset 0 in bit 7", got_b[0], 8'h80);
    for (int k = 0; k < 8; k++) ld(1'b0, k, (k == 7) ? 8'hC3 : 8'h7F);
    run_frame(1, 1'b0, 0);
    chk(got_b[0] == 8'h01, "R4 offset 7 in bit 0", got_b[0], 8'h01);

    // R5: wrap, phase 0x80 value 0x81 -> 0xFF
    ld(1'b0, 8, 8'h80); ld(1'b1, 8, 8'h81);
    run_frame(2, 1'b0, 0);
    chk(m_ph[8] == 8'hFF, "R5 model wrap", m_ph[8], 8'hFF);
    run_frame(2, 1'b0, 0);
    chk(got_b[1][7] == 1'b1, "R5 wrapped phase sign", 32'(got_b[1][7]), 1);

    // R8: zero groups
    @(negedge clk);
    start_i = 1'b1; nblk_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o && !out_valid_o, "R8 immediate done", {done_o, out_valid_o}, 2);
    @(negedge clk);
    chk(!done_o && !busy_o && !out_valid_o, "R8 back to idle", {done_o, busy_o}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule